// File: doc/BRIEF.md
# Serial Receive Character Assembler

The block turns a serial bit stream into characters of five to eight bits. An external strobe marks each valid bit on the data line. When parity is enabled, a parity bit follows each character, and the block checks it against an odd or even setting. Each finished character is written into a three-entry receive queue together with a parity-error flag and an overrun flag. A processor drains the queue one byte at a time through a read strobe.

The stored byte is an 8-bit window of the stream that starts at the first bit of the character. The first bit received lands in bit 0. The parity bit sits directly above the data bits. Any bit positions left over hold the stream bits that came next, which are the first bits of the following character. A character with a parity error or an overrun is a special condition. It locks the queue, so that its status stays readable until the processor sends an error-reset pulse.

Top module: `rx_char_assembler`

## Requirements
- R1: `len_sel` selects the data length as 00 = 5 bits, 01 = 7 bits, 10 = 6 bits, 11 = 8 bits. Bits are received least significant first, and the first data bit of a character appears at `rd_data[0]`.
- R2: With `par_en` = 1 and a data length below 8, the received parity bit is stored at bit position equal to the data length. With 8 data bits, the parity bit is checked but not stored.
- R3: Characters follow one another with no gap, each taking data length plus `par_en` strobes. Stored bits above the character and its parity hold the stream bits that follow it, not zeros.
- R4: `rd_perr` is set when the XOR of the data bits and the parity bit differs from `par_odd` (1 = odd, 0 = even). It is never set while `par_en` = 0.
- R5: A character is written into the queue on the strobe that completes both its frame and an 8-bit window from its first bit. For a frame shorter than 8 bits, that is the 8th strobe counted from its first bit. Before that strobe, `char_avail` stays low.
- R6: The queue holds 3 entries and is read oldest first. `char_avail` is high whenever it is not empty. A read strobe on an empty queue has no effect. `rd_data`, `rd_perr` and `rd_ovr` show the oldest entry.
- R7: Writing a character with a parity error locks the queue. While the queue is locked, no further characters enter it.
- R8: While the queue is locked and the special entry is the only one left, a read does not remove it, and its data and flags stay on the outputs.
- R9: `err_rst` clears the lock and the flags of the newest entry. The next read then removes that entry.
- R10: A character that completes while the queue is full or locked is discarded. It sets `rd_ovr` on the newest entry and locks the queue. A queue that is full at that edge counts as full, even if a read happens in the same cycle.
- R11: After reset the queue is empty, unlocked, and bit counting starts at a character boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe marking a valid stream bit |
| bit_in | input | 1 | Serial data bit, sampled with `bit_stb` |
| len_sel | input | 2 | Data length code (see R1), held static between resets |
| par_en | input | 1 | Parity bit present after each character |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_stb | input | 1 | Read strobe that removes the oldest entry |
| err_rst | input | 1 | Error-reset command pulse |
| rd_data | output | 8 | Oldest entry's stored byte |
| rd_perr | output | 1 | Oldest entry's parity-error flag |
| rd_ovr | output | 1 | Oldest entry's overrun flag |
| char_avail | output | 1 | Queue not empty |

## Verification
The hardest state to reach is a locked queue whose special entry carries both flags while earlier good entries are still waiting in front of it. The bench gets there by building a stream in which the middle character of three has a deliberately wrong parity bit. The third character then overruns into the locked queue. The bench drains the good entry, confirms that reads no longer move the special one, and then issues the error reset. A second path reaches overrun by filling the queue with a fourth character. All length and parity combinations are swept, and all 5-bit values are sent with both correct and flipped parity.

// File: rtl/rxa_pkg.sv
// Shared types and helpers for the serial receive character assembler.
// Assumes a byte-wide stored character and a 2-bit length code.
package rxa_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              perr;
        logic              ovr;
    } rx_entry_t;

    // Data length in bits for a length code.
    function automatic logic [3:0] len_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 4'd5;
            2'b01:   return 4'd7;
            2'b10:   return 4'd6;
            default: return 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/rxa_framer.sv
// Bit framer: shifts the stream into an 8-bit window and counts bits of the
// oldest unfinished character. When that character's frame and its 8-bit
// window are both complete, it emits a write pulse, the snapshot byte and the
// parity verdict. Assumes len/parity settings stay static between resets.
module rxa_framer
    import rxa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_in,
    input  logic [3:0]        data_len,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              chr_wr,
    output logic [BYTE_W-1:0] chr_byte,
    output logic              chr_perr
);
    logic [BYTE_W-1:0] shreg, shreg_nx, snap;
    logic [3:0]        seen, seen_nx, frame_len, close_at;
    logic [BYTE_W-1:0] win, dmask;
    logic              pbit;

    // Frame geometry and next shift value.
    always_comb begin
        frame_len = data_len + {3'b000, par_en};
        close_at  = (frame_len == 4'd9) ? 4'd9 : 4'd8;
        shreg_nx  = {bit_in, shreg[BYTE_W-1:1]};
        seen_nx   = seen + 4'd1;
    end

    // Window selection, parity bit pick-up and write pulse.
    always_comb begin
        win      = (close_at == 4'd8) ? shreg_nx : snap;
        pbit     = (data_len == 4'd8) ? bit_in : win[data_len[2:0]];
        dmask    = 8'hFF >> (4'd8 - data_len);
        chr_wr   = bit_stb && (seen_nx == close_at);
        chr_byte = win;
        chr_perr = par_en && ((^(win & dmask)) ^ pbit ^ par_odd);
    end

    // Shift register, window snapshot and oldest-character bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            snap  <= '0;
            seen  <= '0;
        end else if (bit_stb) begin
            shreg <= shreg_nx;
            if (seen_nx == 4'd8)
                snap <= shreg_nx;
            seen <= (seen_nx == close_at) ? (seen_nx - frame_len) : seen_nx;
        end
    end

    // The count of bits seen for the oldest character never passes 8.
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seen <= 4'd8);
endmodule

// File: rtl/rxa_fifo.sv
// Receive queue with error lock. Holds DEPTH entries of byte plus flags.
// A parity-error write or an overrun locks it. While locked, writes are
// discarded as overruns, and the last remaining entry cannot be popped until
// err_rst. Assumes err_rst is not issued on the same edge as a write.
module rxa_fifo
    import rxa_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_perr,
    input  logic              rd,
    input  logic              err_rst,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_perr,
    output logic              rd_ovr,
    output logic              avail
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    rx_entry_t         mem [DEPTH];
    logic [PW-1:0]     head, tail, newest;
    logic [CW-1:0]     cnt;
    logic              locked, full, drop, do_wr, do_rd;

    // Write, drop and pop decisions for this cycle.
    always_comb begin
        full   = (cnt == FULL_C);
        drop   = wr && (full || locked);
        do_wr  = wr && !drop;
        do_rd  = rd && (cnt != '0) && !(locked && cnt == CW'(1));
        newest = (tail == '0) ? LAST : tail - 1'b1;
    end

    // Storage, pointers, occupancy and lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head   <= '0;
            tail   <= '0;
            cnt    <= '0;
            locked <= 1'b0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else begin
            if (do_wr) begin
                mem[tail] <= '{data: wr_data, perr: wr_perr, ovr: 1'b0};
                tail      <= (tail == LAST) ? '0 : tail + 1'b1;
            end
            if (drop)
                mem[newest].ovr <= 1'b1;
            if (err_rst) begin
                mem[newest].perr <= 1'b0;
                mem[newest].ovr  <= 1'b0;
            end
            if (do_rd)
                head <= (head == LAST) ? '0 : head + 1'b1;
            if (do_wr && !do_rd)
                cnt <= cnt + 1'b1;
            else if (do_rd && !do_wr)
                cnt <= cnt - 1'b1;
            if (err_rst)
                locked <= 1'b0;
            else if ((do_wr && wr_perr) || drop)
                locked <= 1'b1;
        end
    end

    // Oldest entry presented to the reader.
    always_comb begin
        rd_data = mem[head].data;
        rd_perr = mem[head].perr;
        rd_ovr  = mem[head].ovr;
        avail   = (cnt != '0);
    end

    p_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_C);
    p_lock_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr && !rd && !err_rst) |=> $stable(cnt));
    p_special_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && cnt == CW'(1) && !err_rst) |=> cnt == CW'(1));
    p_err_unlocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_rst |=> !locked);
    p_ovr_locks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full && !err_rst) |=> locked);
endmodule

// File: rtl/rx_char_assembler.sv
// Serial receive character assembler top: framer feeding a locking queue.
// Assumes one bit per bit_stb and static length/parity settings per reset.
module rx_char_assembler
    import rxa_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_stb,
    input  logic        bit_in,
    input  logic [1:0]  len_sel,
    input  logic        par_en,
    input  logic        par_odd,
    input  logic        rd_stb,
    input  logic        err_rst,
    output logic [7:0]  rd_data,
    output logic        rd_perr,
    output logic        rd_ovr,
    output logic        char_avail
);
    logic [3:0]        data_len;
    logic              chr_wr, chr_perr;
    logic [BYTE_W-1:0] chr_byte;

    // Length code decode.
    always_comb data_len = len_bits(len_sel);

    rxa_framer u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .bit_in   (bit_in),
        .data_len (data_len),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .chr_wr   (chr_wr),
        .chr_byte (chr_byte),
        .chr_perr (chr_perr)
    );

    rxa_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (chr_wr),
        .wr_data (chr_byte),
        .wr_perr (chr_perr),
        .rd      (rd_stb),
        .err_rst (err_rst),
        .rd_data (rd_data),
        .rd_perr (rd_perr),
        .rd_ovr  (rd_ovr),
        .avail   (char_avail)
    );

    p_avail_after_reset_r11: assert property (@(posedge clk)
        $rose(rst_n) |-> !char_avail);
endmodule

// File: tb/sim_rx_char_assembler.sv
module sim_rx_char_assembler;
    logic clk = 0, rst_n = 0, bit_stb = 0, bit_in = 0;
    logic [1:0] len_sel = 0;
    logic par_en = 0, par_odd = 0, rd_stb = 0, err_rst = 0;
    logic [7:0] rd_data;
    logic rd_perr, rd_ovr, char_avail;

    int total = 0, bad = 0;
    bit done = 0;
    logic [0:127] strm;
    int slen, flen;
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    rx_char_assembler u0 (.*);

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic int len_of(logic [1:0] c);
        case (c) 2'b00: return 5; 2'b01: return 7; 2'b10: return 6; default: return 8; endcase
    endfunction

    task automatic nbit(output logic b);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        b = lf[0];
    endtask

    task automatic do_reset(logic [1:0] ls, logic pe, logic po);
        @(negedge clk);
        rst_n = 0; len_sel = ls; par_en = pe; par_odd = po;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        @(negedge clk); bit_stb = 1; bit_in = b;
        @(negedge clk); bit_stb = 0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_stb = 1;
        @(negedge clk); rd_stb = 0;
    endtask

    task automatic pulse_err();
        @(negedge clk); err_rst = 1;
        @(negedge clk); err_rst = 0;
    endtask

    // Build nchar characters (char badk gets flipped parity) plus trail bits.
    task automatic build(int nchar, int trail, int badk);
        int L;
        logic b, p;
        L = len_of(len_sel);
        flen = L + int'(par_en);
        slen = 0;
        for (int k = 0; k < nchar; k++) begin
            p = par_odd;
            for (int i = 0; i < L; i++) begin
                nbit(b); strm[slen] = b; slen++; p = p ^ b;
            end
            if (par_en) begin
                strm[slen] = p ^ (k == badk); slen++;
            end
        end
        for (int i = 0; i < trail; i++) begin
            nbit(b); strm[slen] = b; slen++;
        end
    endtask

    function automatic logic [7:0] exp_byte(int k);
        logic [7:0] e;
        for (int i = 0; i < 8; i++) e[i] = strm[k * flen + i];
        return e;
    endfunction

    initial begin
        #(200000 * 5);
        bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        // R11 reset state, R6 empty read ignored
        do_reset(2'b00, 0, 0);
        chk("R11 avail after reset", {7'd0, char_avail}, 8'd0);
        pulse_rd();
        chk("R6 empty read", {7'd0, char_avail}, 8'd0);

        // R1 R2 R3 R6: all length and parity settings, three chars each
        for (int cfg = 0; cfg < 16; cfg++) begin
            int m;
            do_reset(cfg[1:0], cfg[2], cfg[3]);
            m = (len_of(cfg[1:0]) + int'(cfg[2]) == 9) ? 9 : 8;
            build(3, m - (len_of(cfg[1:0]) + int'(cfg[2])), -1);
            for (int i = 0; i < slen; i++) send_bit(strm[i]);
            for (int k = 0; k < 3; k++) begin
                chk("R6 avail", {7'd0, char_avail}, 8'd1);
                chk(par_en ? "R2 R3 byte" : "R1 R3 byte", rd_data, exp_byte(k));
                chk("R4 no perr", {7'd0, rd_perr}, 8'd0);
                chk("R10 no ovr", {7'd0, rd_ovr}, 8'd0);
                pulse_rd();
            end
            chk("R6 drained", {7'd0, char_avail}, 8'd0);
        end

        // R4 R5 R8 R9: every 5-bit value with correct and flipped parity
        for (int d = 0; d < 32; d++) begin
            for (int f = 0; f < 2; f++) begin
                logic [4:0] dv;
                logic p;
                dv = d[4:0];
                do_reset(2'b00, 1, dv[1]);
                p = (^dv) ^ dv[1] ^ f[0];
                for (int i = 0; i < 5; i++) strm[i] = dv[i];
                strm[5] = p; strm[6] = d[0]; strm[7] = f[0];
                for (int i = 0; i < 7; i++) send_bit(strm[i]);
                chk("R5 not yet", {7'd0, char_avail}, 8'd0);
                send_bit(strm[7]);
                chk("R5 written", {7'd0, char_avail}, 8'd1);
                flen = 6;
                chk("R2 byte", rd_data, exp_byte(0));
                chk("R4 perr", {7'd0, rd_perr}, {7'd0, f[0]});
                pulse_rd();
                if (f == 1) begin
                    chk("R8 held", {7'd0, char_avail}, 8'd1);
                    chk("R8 perr kept", {7'd0, rd_perr}, 8'd1);
                    pulse_err();
                    chk("R9 perr cleared", {7'd0, rd_perr}, 8'd0);
                    pulse_rd();
                end
                chk("R9 popped", {7'd0, char_avail}, 8'd0);
            end
        end

        // R7 R10: bad middle char locks; third char overruns
        do_reset(2'b01, 1, 0);
        build(3, 0, 1);
        for (int i = 0; i < slen; i++) send_bit(strm[i]);
        chk("R7 good first", rd_data, exp_byte(0));
        chk("R7 first clean", {6'd0, rd_perr, rd_ovr}, 8'd0);
        pulse_rd();
        chk("R7 special byte", rd_data, exp_byte(1));
        chk("R10 flags", {6'd0, rd_perr, rd_ovr}, 8'd3);
        pulse_rd();
        pulse_rd();
        chk("R8 still held", {7'd0, char_avail}, 8'd1);
        chk("R8 byte kept", rd_data, exp_byte(1));
        pulse_err();
        chk("R9 flags clear", {6'd0, rd_perr, rd_ovr}, 8'd0);
        pulse_rd();
        chk("R9 empty", {7'd0, char_avail}, 8'd0);
        build(1, 0, -1);
        for (int i = 0; i < slen; i++) send_bit(strm[i]);
        chk("R9 unlocked write", rd_data, exp_byte(0));
        pulse_rd();

        // R10: overrun by a full queue
        do_reset(2'b11, 0, 0);
        build(4, 0, -1);
        for (int i = 0; i < slen; i++) send_bit(strm[i]);
        chk("R6 oldest", rd_data, exp_byte(0));
        pulse_rd();
        chk("R6 second", rd_data, exp_byte(1));
        pulse_rd();
        chk("R10 newest kept", rd_data, exp_byte(2));
        chk("R10 ovr set", {6'd0, rd_perr, rd_ovr}, 8'd1);
        pulse_rd();
        chk("R10 locked hold", {7'd0, char_avail}, 8'd1);
        pulse_err();
        pulse_rd();
        chk("R10 cleared", {7'd0, char_avail}, 8'd0);

        report();
    end
endmodule